// File: doc/BRIEF.md
# Steerable Interrupt Controller with Wake and Idle Exit

This block gathers 32 level-sensitive interrupt requests, gates them with a per-source enable mask and sends each enabled request to one of two outputs: a normal interrupt line or a fast interrupt line, chosen per source by a routing register. Bits 0 to 10 of the source vector carry individual GPIO lines and bit 11 carries the merged request of GPIO 11 to 27. The other bits carry on-chip peripherals. Requests are not latched. A source is pending while its input is high and stops being pending when the input falls, so no acknowledge is ever written.

Two more outputs serve power management. A wake output rises when a GPIO status line (0 to 27) or the alarm input is high and its wake-enable bit is set. The mask has no effect on this output. An idle-exit output tells a core in wait-for-interrupt idle to resume. When the strict idle bit is set, only unmasked requests raise it. When the bit is clear, any raw request raises it.

Software uses a small word-addressed register bus. Reads are combinational. A write is captured on the rising clock edge when the write strobe is high. All four event outputs are registered.

Top module: `intr_steer_ctrl`

## Requirements
- R1: After synchronous reset, the mask, routing, strict idle and wake-enable registers all read zero, and irq_out, fiq_out, idle_exit and wake_out are low.
- R2: irq_out is high one clock edge after any source that has mask bit 1 and routing bit 0 is high. Offset 0x00 reads src_in & mask & ~route.
- R3: fiq_out is high one clock edge after any source that has mask bit 1 and routing bit 1 is high. Offset 0x10 reads src_in & mask & route.
- R4: A source whose mask bit is 0 raises neither irq_out nor fiq_out, and it reads as 0 in both pending words.
- R5: Requests are level-sensitive. When a source input falls, its output contribution is gone one clock edge later, with no acknowledge write.
- R6: Mask (0x04) and routing (0x08) read back all 32 written bits. Control (0x0C) keeps only bit 0, and its other bits read zero. Wake-enable (0x14) keeps bits 0 to 27 (GPIO) and bit 31 (alarm), and bits 28 to 30 read zero.
- R7: Writes to the read-only pending offsets 0x00 and 0x10 change no register.
- R8: With control bit 0 set, idle_exit is high one edge after a source that is both high and unmasked, and stays low for sources that are only masked.
- R9: With control bit 0 clear, idle_exit is high one edge after any high source, whether masked or not.
- R10: wake_out is high one edge after (gpio_lvl[i] & wake bit i) for some i in 0..27, or alarm_in & wake bit 31. The mask register does not affect it.
- R11: A register write and a source change made in the same cycle both take effect. The edge that captures the write drives the outputs from the new source and the old mask. The next edge drives them from the new source and the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_in | input | 32 | Level-sensitive interrupt sources |
| gpio_lvl | input | 28 | GPIO status lines used for wake |
| alarm_in | input | 1 | Real-time-clock alarm request |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |
| idle_exit | output | 1 | Ends wait-for-interrupt idle |
| wake_out | output | 1 | Wake request for sleep |

## Verification
A mask write and a source transition can arrive in the same cycle. The bench provokes this by changing src_in in the same cycle that it writes a mask that enables a different set of sources. It then compares both output edges that follow. The first edge must show the new source gated by the old mask, and the second must show the new mask. Because the bench chooses values where the two combinations give different irq_out and fiq_out results, a design that applies the write too early or too late is caught.

// File: rtl/intr_steer_pkg.sv
package intr_steer_pkg;

    localparam int SRC_W     = 32;
    localparam int GPIO_W    = 28;
    localparam int ADDR_W    = 5;
    localparam int ALARM_BIT = SRC_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        OFS_IRQ_PEND = 5'h00,
        OFS_MASK     = 5'h04,
        OFS_ROUTE    = 5'h08,
        OFS_CTRL     = 5'h0C,
        OFS_FIQ_PEND = 5'h10,
        OFS_WAKE     = 5'h14
    } reg_ofs_e;

    typedef struct packed {
        logic [SRC_W-1:0] mask;
        logic [SRC_W-1:0] route;
        logic [SRC_W-1:0] wake;
        logic             idle_strict;
    } cfg_t;

    typedef struct packed {
        logic [SRC_W-1:0] irq;
        logic [SRC_W-1:0] fiq;
    } pend_t;

    // Bits of the wake-enable register that hold storage.
    function automatic logic [SRC_W-1:0] wake_keep();
        logic [SRC_W-1:0] k;
        k = '0;
        for (int i = 0; i < GPIO_W; i++) k[i] = 1'b1;
        k[ALARM_BIT] = 1'b1;
        return k;
    endfunction

endpackage

// File: rtl/intr_regfile.sv
module intr_regfile
    import intr_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [SRC_W-1:0]  wdata,
    input  pend_t             pend,
    output cfg_t              cfg,
    output logic [SRC_W-1:0]  rdata
);
    localparam logic [SRC_W-1:0] KEEP = wake_keep();

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            case (reg_ofs_e'(addr))
                OFS_MASK:  cfg_q.mask        <= wdata;
                OFS_ROUTE: cfg_q.route       <= wdata;
                OFS_CTRL:  cfg_q.idle_strict <= wdata[0];
                OFS_WAKE:  cfg_q.wake        <= wdata & KEEP;
                default:   ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_ofs_e'(addr))
            OFS_IRQ_PEND: rdata = pend.irq;
            OFS_MASK:     rdata = cfg_q.mask;
            OFS_ROUTE:    rdata = cfg_q.route;
            OFS_CTRL:     rdata = {{(SRC_W-1){1'b0}}, cfg_q.idle_strict};
            OFS_FIQ_PEND: rdata = pend.fiq;
            OFS_WAKE:     rdata = cfg_q.wake;
            default:      rdata = '0;
        endcase
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/intr_router.sv
module intr_router
    import intr_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src,
    input  cfg_t             cfg,
    output pend_t            pend,
    output logic             irq_q,
    output logic             fiq_q
);
    logic [SRC_W-1:0] irq_v;
    logic [SRC_W-1:0] fiq_v;

    for (genvar g = 0; g < SRC_W; g++) begin : g_lane
        logic live;
        assign live     = src[g] & cfg.mask[g];
        assign irq_v[g] = live & ~cfg.route[g];
        assign fiq_v[g] = live &  cfg.route[g];
    end

    assign pend.irq = irq_v;
    assign pend.fiq = fiq_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |irq_v;
            fiq_q <= |fiq_v;
        end
    end
endmodule

// File: rtl/intr_wake.sv
module intr_wake
    import intr_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  src,
    input  logic [GPIO_W-1:0] gpio,
    input  logic              alarm,
    input  cfg_t              cfg,
    output logic              idle_q,
    output logic              wake_q
);
    logic [SRC_W-1:0] wake_src;
    logic             idle_d;

    always_comb begin
        wake_src             = '0;
        wake_src[GPIO_W-1:0] = gpio;
        wake_src[ALARM_BIT]  = alarm;
    end

    always_comb begin
        if (cfg.idle_strict) idle_d = |(src & cfg.mask);
        else                 idle_d = |src;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            idle_q <= idle_d;
            wake_q <= |(wake_src & cfg.wake);
        end
    end
endmodule

// File: rtl/intr_steer_ctrl.sv
module intr_steer_ctrl
    import intr_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [SRC_W-1:0]  bus_wdata,
    output logic [SRC_W-1:0]  bus_rdata,
    input  logic [SRC_W-1:0]  src_in,
    input  logic [GPIO_W-1:0] gpio_lvl,
    input  logic              alarm_in,
    output logic              irq_out,
    output logic              fiq_out,
    output logic              idle_exit,
    output logic              wake_out
);
    cfg_t  cfg;
    pend_t pend;

    intr_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .pend  (pend),
        .cfg   (cfg),
        .rdata (bus_rdata)
    );

    intr_router u_route (
        .clk   (clk),
        .rst   (rst),
        .src   (src_in),
        .cfg   (cfg),
        .pend  (pend),
        .irq_q (irq_out),
        .fiq_q (fiq_out)
    );

    intr_wake u_wake (
        .clk    (clk),
        .rst    (rst),
        .src    (src_in),
        .gpio   (gpio_lvl),
        .alarm  (alarm_in),
        .cfg    (cfg),
        .idle_q (idle_exit),
        .wake_q (wake_out)
    );
endmodule

// File: rtl/intr_steer_checker.sv
module intr_steer_checker
    import intr_steer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [SRC_W-1:0]  src_in,
    input logic [GPIO_W-1:0] gpio_lvl,
    input logic              alarm_in,
    input logic              irq_out,
    input logic              fiq_out,
    input logic              idle_exit,
    input logic              wake_out,
    input cfg_t              cfg
);
    AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_out == $past(|(src_in & cfg.mask & ~cfg.route))); // R2
    AST_FIQ_TRACK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> fiq_out == $past(|(src_in & cfg.mask & cfg.route))); // R3
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        ((src_in & cfg.mask) == '0) |=> (!irq_out && !fiq_out)); // R4
    AST_PEND_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == OFS_IRQ_PEND || bus_addr == OFS_FIQ_PEND)) |=> $stable(cfg)); // R7
    AST_WAKE_RESERVED: assert property (@(posedge clk) disable iff (rst)
        cfg.wake[ALARM_BIT-1:GPIO_W] == '0); // R6
    AST_IDLE_STRICT: assert property (@(posedge clk) disable iff (rst)
        cfg.idle_strict |=> idle_exit == $past(|(src_in & cfg.mask))); // R8
    AST_IDLE_LOOSE: assert property (@(posedge clk) disable iff (rst)
        !cfg.idle_strict |=> idle_exit == $past(|src_in)); // R9
    AST_WAKE_SOURCES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> wake_out == $past(|(gpio_lvl & cfg.wake[GPIO_W-1:0]) |
                                   (alarm_in & cfg.wake[ALARM_BIT]))); // R10
endmodule

bind intr_steer_ctrl intr_steer_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .src_in    (src_in),
    .gpio_lvl  (gpio_lvl),
    .alarm_in  (alarm_in),
    .irq_out   (irq_out),
    .fiq_out   (fiq_out),
    .idle_exit (idle_exit),
    .wake_out  (wake_out),
    .cfg       (cfg)
);

// File: tb/tb_intr_steer_ctrl.sv
module tb_intr_steer_ctrl;
    import intr_steer_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [SRC_W-1:0]  bus_wdata = '0;
    logic [SRC_W-1:0]  bus_rdata;
    logic [SRC_W-1:0]  src_in = '0;
    logic [GPIO_W-1:0] gpio_lvl = '0;
    logic              alarm_in = 1'b0;
    logic              irq_out, fiq_out, idle_exit, wake_out;

    intr_steer_ctrl dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .gpio_lvl(gpio_lvl), .alarm_in(alarm_in), .irq_out(irq_out),
        .fiq_out(fiq_out), .idle_exit(idle_exit), .wake_out(wake_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef enum int { K_IRQ, K_FIQ, K_IDLE, K_WAKE, K_READ } kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    checks   = 0;
    int    failures = 0;
    bit    done     = 1'b0;

    // bench model of the registers
    logic [31:0] m_mask = '0, m_route = '0, m_wake = '0;
    logic        m_strict = 1'b0;

    // monitor
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                K_IRQ:   act = {31'b0, irq_out};
                K_FIQ:   act = {31'b0, fiq_out};
                K_IDLE:  act = {31'b0, idle_exit};
                K_WAKE:  act = {31'b0, wake_out};
                default: act = bus_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic push(kind_e k, logic [31:0] e, string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        cyc();
        bus_we = 1'b0;
        case (a)
            5'h04: m_mask   = d;
            5'h08: m_route  = d;
            5'h0C: m_strict = d[0];
            5'h14: m_wake   = d & 32'h8FFF_FFFF;
            default: ;
        endcase
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] e, string r);
        bus_addr = a;
        push(K_READ, e, r);
        cyc();
    endtask

    // outputs expected from the model after settling
    task automatic outs(string r);
        logic [31:0] wsrc;
        wsrc = {alarm_in, 3'b000, gpio_lvl};
        push(K_IRQ,  {31'b0, |(src_in & m_mask & ~m_route)}, r);
        push(K_FIQ,  {31'b0, |(src_in & m_mask & m_route)}, r);
        push(K_IDLE, {31'b0, m_strict ? |(src_in & m_mask) : |src_in}, r);
        push(K_WAKE, {31'b0, |(wsrc & m_wake)}, r);
        cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        cyc();
        // R1 reset state
        rd(5'h04, 32'h0, "R1 mask");
        rd(5'h08, 32'h0, "R1 route");
        rd(5'h0C, 32'h0, "R1 ctrl");
        rd(5'h14, 32'h0, "R1 wake");
        outs("R1 outputs");

        // R2 R3 steering
        wr(5'h04, 32'h0000_0F0F);
        wr(5'h08, 32'h0000_0F00);
        src_in = 32'h0000_0303;
        cyc();
        push(K_IRQ, 32'h1, "R2 irq_out");
        push(K_FIQ, 32'h1, "R3 fiq_out");
        cyc();
        rd(5'h00, 32'h0000_0003, "R2 irq pending");
        rd(5'h10, 32'h0000_0300, "R3 fiq pending");

        // R4 masked sources only
        src_in = 32'h0000_F0F0;
        cyc();
        push(K_IRQ, 32'h0, "R4 irq_out");
        push(K_FIQ, 32'h0, "R4 fiq_out");
        cyc();
        rd(5'h00, 32'h0, "R4 irq pending");
        rd(5'h10, 32'h0, "R4 fiq pending");

        // R5 level behaviour, exact one-edge timing
        src_in = 32'h0000_0001;
        cyc();
        push(K_IRQ, 32'h1, "R5 rise");
        src_in = 32'h0;
        cyc();
        push(K_IRQ, 32'h0, "R5 fall");
        cyc();

        // R6 readback
        rd(5'h04, 32'h0000_0F0F, "R6 mask");
        rd(5'h08, 32'h0000_0F00, "R6 route");
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, 32'h0000_0001, "R6 ctrl");
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, 32'h8FFF_FFFF, "R6 wake");

        // R7 writes to pending offsets ignored
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h04, 32'h0000_0F0F, "R7 mask kept");
        rd(5'h08, 32'h0000_0F00, "R7 route kept");
        rd(5'h0C, 32'h0000_0001, "R7 ctrl kept");
        rd(5'h14, 32'h8FFF_FFFF, "R7 wake kept");
        wr(5'h14, 32'h0);

        // R8 strict idle
        src_in = 32'h0000_F000;
        cyc();
        push(K_IDLE, 32'h0, "R8 masked only");
        cyc();
        src_in = 32'h0000_0001;
        cyc();
        push(K_IDLE, 32'h1, "R8 unmasked");
        cyc();

        // R9 loose idle
        wr(5'h0C, 32'h0);
        src_in = 32'h0000_F000;
        cyc();
        push(K_IDLE, 32'h1, "R9 masked source");
        cyc();
        src_in = 32'h0;
        cyc();
        push(K_IDLE, 32'h0, "R9 no source");
        cyc();

        // R10 wake, mask cleared
        wr(5'h04, 32'h0);
        wr(5'h14, 32'h8000_0004);
        gpio_lvl = 28'h000_0008;
        cyc();
        push(K_WAKE, 32'h0, "R10 disabled pin");
        cyc();
        gpio_lvl = 28'h000_0004;
        cyc();
        push(K_WAKE, 32'h1, "R10 enabled pin");
        cyc();
        gpio_lvl = '0;
        alarm_in = 1'b1;
        cyc();
        push(K_WAKE, 32'h1, "R10 alarm");
        cyc();
        alarm_in = 1'b0;
        cyc();
        outs("R10 idle");

        // R11 write and source change in the same cycle
        wr(5'h04, 32'h0000_0F0F);
        src_in = 32'h0000_0001;
        cyc();
        cyc();
        src_in = 32'h0000_0101;
        wr(5'h04, 32'h0000_0100);
        push(K_IRQ, 32'h1, "R11 first edge irq");
        push(K_FIQ, 32'h1, "R11 first edge fiq");
        cyc();
        push(K_IRQ, 32'h0, "R11 second edge irq");
        push(K_FIQ, 32'h1, "R11 second edge fiq");
        cyc();
        outs("R11 settled");

        cyc();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule